// File: doc/BRIEF.md
# Line-Side Hook Fail-Safe Supervisor

This block owns the hook state of an isolated telephone line interface. The host asks for off-hook through a level request. The supervisor grants it only when no fault condition is present. It drops back to on-hook as soon as a fault appears. Three events count as faults:
- a power-on reset on the line side;
- a supply-below-normal flag;
- loss of activity on the barrier receive line.

Activity is lost when the line, after a two-flop synchronizer, shows no edge for a programmed number of clock cycles. The default is 400 µs at the configured clock. A host bit can switch this watchdog off.

Each forced drop sets a sticky cause flag, one per cause. The flags stay set until the host clears them. After the clear, the host must withdraw its request and raise it again before the line can go off-hook once more. The block also reports the operating mode:
- idle while on-hook;
- hold when both the AC and DC path enables are set;
- seize when only the DC enable is set.

Top module: `hook_failsafe_sup`

## Requirements
- R1: After the synchronous reset, offhook_o is 0, mode_o is 0 (idle) and all three fault flags are 0.
- R2: With no fault flag set and no fault condition present, offhook_o becomes 1 one clock edge after hook_req_i is sampled high, and returns to 0 one edge after hook_req_i is sampled low.
- R3: If por_i is sampled high while offhook_o is 1, offhook_o is 0 and fault_por_o is 1 after that edge.
- R4: If supply_ok_i is sampled low while offhook_o is 1, offhook_o is 0 and fault_sup_o is 1 after that edge.
- R5: While off-hook with the watchdog enabled, a synchronized barrier line with no edge keeps offhook_o high for exactly WD_LIMIT+1 cycles, where WD_LIMIT = CLK_KHZ*WD_TIMEOUT_US/1000. Then offhook_o falls and fault_wd_o is set. Edges spaced closer than WD_LIMIT cycles keep the line off-hook indefinitely.
- R6: While wd_disable_i is 1, a silent barrier line never forces on-hook.
- R7: While off-hook, mode_o encodes the enables sampled at the previous edge: 1 (hold) for AC=1 and DC=1; 2 (seize) for AC=0 and DC=1; 0 (idle) when DC=0. It changes with the same one-edge latency as offhook_o.
- R8: While offhook_o is 0, mode_o is 0 whatever the enables are.
- R9: Fault flags stay set until fault_clr_i is sampled high. While any flag is set, offhook_o stays 0 even with hook_req_i held high.
- R10: After the flags are cleared, offhook_o stays 0 until hook_req_i has been sampled low at least once with all flags clear and then sampled high again.
- R11: A fault condition present while on-hook sets no fault flag, but it holds the line on-hook. When the condition goes away, a standing request takes the line off-hook at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hook_req_i | input | 1 | Host request for off-hook (level) |
| ac_en_i | input | 1 | AC path enable |
| dc_en_i | input | 1 | DC path enable |
| wd_disable_i | input | 1 | Turns the barrier activity watchdog off |
| por_i | input | 1 | Line-side power-on reset indication |
| supply_ok_i | input | 1 | Line-side supply at normal level |
| barrier_rx_i | input | 1 | Asynchronous barrier receive data line |
| fault_clr_i | input | 1 | Clears all sticky fault flags |
| offhook_o | output | 1 | 1 = off-hook, 0 = on-hook |
| mode_o | output | 2 | 0 idle, 1 hold, 2 seize |
| fault_por_o | output | 1 | Sticky: dropped by power-on reset |
| fault_sup_o | output | 1 | Sticky: dropped by low supply |
| fault_wd_o | output | 1 | Sticky: dropped by barrier watchdog |

## Verification
The assertions check a set of rules on every cycle:
- a reset or supply fault while off-hook gives on-hook and the matching flag at the next edge;
- no flag is set while off-hook;
- the line never goes off-hook without a sampled request;
- the mode is idle whenever on-hook and otherwise matches the enables sampled one edge earlier.

The bench scenarios cover what needs history or a long window:
- the exact WD_LIMIT+1 cycle survival on a silent line, and periodic edges keeping the line up;
- the disable bit overriding the watchdog;
- the flags holding through a standing request;
- the withdraw-and-reassert needed after a clear;
- triggers applied while on-hook.

// File: rtl/hook_sup_pkg.sv
package hook_sup_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_SEIZE = 2'd2
  } line_mode_e;

  // Cause indices inside the fault vector
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_SUP = 1;
  localparam int CAUSE_WD  = 2;
  localparam int N_CAUSES  = 3;

  function automatic line_mode_e decode_mode(input logic off, input logic ac, input logic dc);
    if (!off || !dc) return MODE_IDLE;
    else if (ac)     return MODE_HOLD;
    else             return MODE_SEIZE;
  endfunction

endpackage

// File: rtl/hook_sync_edge.sv
module hook_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its delayed copy
  logic [STAGES:0] sh;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh[0] <= 1'b0;
          else     sh[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh[g] <= 1'b0;
          else     sh[g] <= sh[g-1];
        end
      end
    end
  endgenerate

  assign edge_o = sh[STAGES] ^ sh[STAGES-1];

endmodule

// File: rtl/hook_activity_wd.sv
module hook_activity_wd #(
  parameter int WD_LIMIT = 40000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic disable_i,
  input  logic edge_i,
  output logic trip_o
);
  localparam int W = $clog2(WD_LIMIT + 1);
  localparam logic [W-1:0] LIMIT_V = W'(WD_LIMIT);

  logic [W-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_i || disable_i || edge_i) quiet_cnt <= '0;
    else if (quiet_cnt != LIMIT_V)             quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign trip_o = run_i && !disable_i && (quiet_cnt == LIMIT_V);

endmodule

// File: rtl/hook_fault_log.sv
module hook_fault_log #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         record_i,
  input  logic [N-1:0] cause_i,
  input  logic         clr_i,
  input  logic         req_i,
  output logic [N-1:0] sticky_o,
  output logic         block_o
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)                         sticky_o[i] <= 1'b0;
        else if (record_i && cause_i[i]) sticky_o[i] <= 1'b1;
        else if (clr_i)                  sticky_o[i] <= 1'b0;
      end
    end
  endgenerate

  // Rearm gate: released only by a withdrawn request once all flags are clear
  always_ff @(posedge clk) begin
    if (rst)                          block_o <= 1'b0;
    else if (record_i)                block_o <= 1'b1;
    else if (!req_i && !(|sticky_o))  block_o <= 1'b0;
  end

endmodule

// File: rtl/hook_failsafe_sup.sv
module hook_failsafe_sup
  import hook_sup_pkg::*;
#(
  parameter int CLK_KHZ       = 100000,
  parameter int WD_TIMEOUT_US = 400,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hook_req_i,
  input  logic       ac_en_i,
  input  logic       dc_en_i,
  input  logic       wd_disable_i,
  input  logic       por_i,
  input  logic       supply_ok_i,
  input  logic       barrier_rx_i,
  input  logic       fault_clr_i,
  output logic       offhook_o,
  output logic [1:0] mode_o,
  output logic       fault_por_o,
  output logic       fault_sup_o,
  output logic       fault_wd_o
);
  localparam int WD_LIMIT = CLK_KHZ * WD_TIMEOUT_US / 1000;

  logic                rx_edge;
  logic                wd_trip;
  logic [N_CAUSES-1:0] cause;
  logic [N_CAUSES-1:0] sticky;
  logic                blocked;
  logic                any_trig;
  logic                offhook_q;
  logic                offhook_d;
  line_mode_e          mode_q;
  line_mode_e          mode_d;

  hook_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (barrier_rx_i),
    .edge_o (rx_edge)
  );

  hook_activity_wd #(.WD_LIMIT(WD_LIMIT)) u_wd (
    .clk       (clk),
    .rst       (rst),
    .run_i     (offhook_q),
    .disable_i (wd_disable_i),
    .edge_i    (rx_edge),
    .trip_o    (wd_trip)
  );

  always_comb begin
    cause            = '0;
    cause[CAUSE_POR] = por_i;
    cause[CAUSE_SUP] = !supply_ok_i;
    cause[CAUSE_WD]  = wd_trip;
  end

  assign any_trig = |cause;

  hook_fault_log #(.N(N_CAUSES)) u_log (
    .clk      (clk),
    .rst      (rst),
    .record_i (offhook_q && any_trig),
    .cause_i  (cause),
    .clr_i    (fault_clr_i),
    .req_i    (hook_req_i),
    .sticky_o (sticky),
    .block_o  (blocked)
  );

  assign offhook_d = hook_req_i && !any_trig && !(|sticky) && !blocked;
  assign mode_d    = decode_mode(offhook_d, ac_en_i, dc_en_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      offhook_q <= 1'b0;
      mode_q    <= MODE_IDLE;
    end else begin
      offhook_q <= offhook_d;
      mode_q    <= mode_d;
    end
  end

  assign offhook_o   = offhook_q;
  assign mode_o      = mode_q;
  assign fault_por_o = sticky[CAUSE_POR];
  assign fault_sup_o = sticky[CAUSE_SUP];
  assign fault_wd_o  = sticky[CAUSE_WD];

endmodule

// File: rtl/hook_failsafe_sup_chk.sv
module hook_failsafe_sup_chk (
  input logic       clk,
  input logic       rst,
  input logic       hook_req_i,
  input logic       ac_en_i,
  input logic       dc_en_i,
  input logic       por_i,
  input logic       supply_ok_i,
  input logic       offhook_o,
  input logic [1:0] mode_o,
  input logic       fault_por_o,
  input logic       fault_sup_o,
  input logic       fault_wd_o
);

  a_r3_por_forces_onhook: assert property (@(posedge clk) disable iff (rst)
    (offhook_o && por_i) |=> (!offhook_o && fault_por_o));

  a_r4_supply_forces_onhook: assert property (@(posedge clk) disable iff (rst)
    (offhook_o && !supply_ok_i) |=> (!offhook_o && fault_sup_o));

  a_r9_flag_means_onhook: assert property (@(posedge clk) disable iff (rst)
    (fault_por_o || fault_sup_o || fault_wd_o) |-> !offhook_o);

  a_r2_rise_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(offhook_o) |-> $past(hook_req_i));

  a_r8_idle_onhook: assert property (@(posedge clk) disable iff (rst)
    !offhook_o |-> (mode_o == 2'd0));

  a_r7_mode_tracks_enables: assert property (@(posedge clk) disable iff (rst)
    offhook_o |-> (mode_o == (!$past(dc_en_i) ? 2'd0 : ($past(ac_en_i) ? 2'd1 : 2'd2))));

endmodule

bind hook_failsafe_sup hook_failsafe_sup_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .hook_req_i  (hook_req_i),
  .ac_en_i     (ac_en_i),
  .dc_en_i     (dc_en_i),
  .por_i       (por_i),
  .supply_ok_i (supply_ok_i),
  .offhook_o   (offhook_o),
  .mode_o      (mode_o),
  .fault_por_o (fault_por_o),
  .fault_sup_o (fault_sup_o),
  .fault_wd_o  (fault_wd_o)
);

// File: tb/hook_failsafe_sup_tb.sv
`timescale 1ns/1ps
module hook_failsafe_sup_tb;
  localparam int TB_KHZ  = 60;
  localparam int TB_US   = 400;
  localparam int LIMIT   = TB_KHZ * TB_US / 1000;   // 24 cycles

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hook_req = 0, ac_en = 0, dc_en = 0, wd_dis = 0, por = 0;
  logic sup_ok = 1, rx = 0, fclr = 0;
  logic offhook, f_por, f_sup, f_wd;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  logic tog_en = 1'b1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hook_failsafe_sup #(.CLK_KHZ(TB_KHZ), .WD_TIMEOUT_US(TB_US)) u_dut (
    .clk(clk), .rst(rst), .hook_req_i(hook_req), .ac_en_i(ac_en), .dc_en_i(dc_en),
    .wd_disable_i(wd_dis), .por_i(por), .supply_ok_i(sup_ok), .barrier_rx_i(rx),
    .fault_clr_i(fclr), .offhook_o(offhook), .mode_o(mode),
    .fault_por_o(f_por), .fault_sup_o(f_sup), .fault_wd_o(f_wd)
  );

  // Barrier activity: one toggle every 5 cycles while enabled
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (tog_en) begin
        ph++;
        if (ph >= 5) begin rx = ~rx; ph = 0; end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int exp_mode(input int a, input int d);
    if (d == 0) return 0;
    return (a != 0) ? 1 : 2;
  endfunction

  // Clear flags, withdraw and re-raise the request
  task automatic rearm();
    fclr = 1; hook_req = 0; tick();
    fclr = 0; tick();
    hook_req = 1; tick();
  endtask

  // Cycles offhook stays high on a silent barrier
  task automatic measure_silent(output int n);
    n = 0;
    while (offhook && n < 10 * LIMIT) begin n++; tick(); end
  endtask

  initial begin
    int n;
    tick(3);
    rst = 0; tick();
    // R1
    check("R1 offhook", offhook, 0);
    check("R1 mode", mode, 0);
    check("R1 flags", {f_por, f_sup, f_wd}, 0);

    // R2
    hook_req = 1; tick();
    check("R2 offhook after request", offhook, 1);

    // R7 sweep of enables while off-hook
    for (int c = 0; c < 4; c++) begin
      ac_en = c[0]; dc_en = c[1]; tick();
      check("R7 mode off-hook", mode, exp_mode(c[0], c[1]));
      check("R7 still off-hook", offhook, 1);
    end

    // R8: drop request with enables set
    ac_en = 1; dc_en = 1; hook_req = 0; tick();
    check("R2 onhook after withdraw", offhook, 0);
    for (int c = 0; c < 4; c++) begin
      ac_en = c[0]; dc_en = c[1]; tick();
      check("R8 mode on-hook", mode, 0);
    end

    // R3 with R9 and R10
    ac_en = 0; dc_en = 1;
    hook_req = 1; tick();
    check("R2 offhook again", offhook, 1);
    por = 1; tick(); por = 0;
    check("R3 offhook", offhook, 0);
    check("R3 fault_por", f_por, 1);
    check("R3 other flags", {f_sup, f_wd}, 0);
    tick(5);
    check("R9 flag held", f_por, 1);
    check("R9 onhook held", offhook, 0);
    fclr = 1; tick(); fclr = 0;
    check("R9 cleared", f_por, 0);
    tick(3);
    check("R10 no rearm with standing request", offhook, 0);
    hook_req = 0; tick();
    hook_req = 1; tick();
    check("R10 rearm after withdraw", offhook, 1);

    // R4
    sup_ok = 0; tick(); sup_ok = 1;
    check("R4 offhook", offhook, 0);
    check("R4 fault_sup", f_sup, 1);
    check("R4 other flags", {f_por, f_wd}, 0);
    rearm();
    check("R10 rearm after supply fault", offhook, 1);

    // R5 silent barrier
    hook_req = 0; tog_en = 0; fclr = 1; tick(); fclr = 0; tick(4);
    hook_req = 1; tick();
    measure_silent(n);
    check("R5 silent window", n, LIMIT + 1);
    check("R5 fault_wd", f_wd, 1);

    // R5 periodic edges keep it up
    tog_en = 1;
    rearm();
    n = 0;
    for (int i = 0; i < 4 * LIMIT; i++) begin tick(); if (!offhook) n++; end
    check("R5 active barrier keeps off-hook", n, 0);
    check("R5 no wd flag", f_wd, 0);

    // R6 disable
    wd_dis = 1; tog_en = 0;
    n = 0;
    for (int i = 0; i < 4 * LIMIT; i++) begin tick(); if (!offhook) n++; end
    check("R6 disabled watchdog", n, 0);
    check("R6 no wd flag", f_wd, 0);
    wd_dis = 0; tick();
    measure_silent(n);
    check("R5 window after re-enable", n, LIMIT);
    check("R5 fault_wd after re-enable", f_wd, 1);

    // R11 triggers while on-hook
    tog_en = 1;
    hook_req = 0; fclr = 1; tick(); fclr = 0; tick();
    por = 1; tick();
    check("R11 por on-hook no flag", f_por, 0);
    hook_req = 1; tick(2);
    check("R11 por blocks off-hook", offhook, 0);
    por = 0; tick();
    check("R11 off-hook after por release", offhook, 1);
    hook_req = 0; tick();
    sup_ok = 0; hook_req = 1; tick(2);
    check("R11 low supply blocks", offhook, 0);
    check("R11 low supply no flag", f_sup, 0);
    sup_ok = 1; tick();
    check("R11 off-hook after supply good", offhook, 1);

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=%0d expected=finish", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule